// File: doc/BRIEF.md
# Transmit Datapath Control Register Bank

This block holds the configuration bytes for a dual-channel transmit datapath. A host reaches it through a plain parallel port: an address, a write byte, a write strobe and a read byte. Three bytes are mapped, at addresses 0x00, 0x01 and 0x02. Their fields drive named control outputs straight to the datapath. These cover power states, the reference scheme, interpolation and modulation selection, input data format, port arrangement, clock polarities and IQ ordering.

The block has two reset scopes. The hardware reset input clears everything. A soft reset is requested by setting bit 5 in a write to address 0x00, and it clears every byte except address 0x00 itself. The soft reset also sends a one-cycle restart pulse to the datapath. Bit 1 of address 0x00 is read-only and always reflects the live lock-status input.

Top module: `txcfg_regbank`

## Requirements
- R1: While `rstHw` is high, all bytes take their defaults: address 0x00 = 0x00, 0x01 = 0x04, 0x02 = 0x00. This includes address 0x00.
- R2: At address 0x00 only bits 7, 6, 4, 3 and 2 store written data. Bit 1 always reads the current `lockIn` level. Bits 5 and 0 always read 0.
- R3: Address 0x01 stores all eight written bits and reads them back unchanged.
- R4: Address 0x02 stores bits 7:4 and 2:0. Bit 3 ignores writes and reads 0.
- R5: A read of any address above 0x02 returns 0x00. A write there leaves all mapped bytes unchanged.
- R6: A write to 0x00 with bit 5 set raises `dpRestart` for exactly the next cycle. On the clock edge that ends that cycle, addresses 0x01 and 0x02 return to their defaults.
- R7: A soft reset leaves address 0x00 holding the value that the triggering write stored.
- R8: A write to 0x01 or 0x02 made during the `dpRestart` cycle is discarded, because the soft reset wins.
- R9: The field outputs mirror the stored bits as follows. Address 0x00: bit7 `sdioBidir`, bit6 `lsbFirst`, bit4 `sleepEn`, bit3 `powerDown`, bit2 `oneResMode`. Address 0x01: 7:6 `interpSel`, 5:4 `modSel`, 3 `zeroStuff`, 2 `realMix`, 1 `negSideband`, 0 `dclkOutSel`. Address 0x02: 7 `straightBin`, 6 `onePortMode`, 5 `dclkStrong`, 4 `dclkInvert`, 2 `opClkInvert`, 1 `iqSelInvert`, 0 `qiOrder`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstHw | input | 1 | Asynchronous active-high hardware reset |
| regAddr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write byte |
| wrEn | input | 1 | Write strobe |
| rdData | output | 8 | Read byte for regAddr |
| lockIn | input | 1 | Live lock status, 1 = locked |
| sdioBidir | output | 1 | Host data line may also drive |
| lsbFirst | output | 1 | Host transfers LSB first |
| sleepEn | output | 1 | Output currents off |
| powerDown | output | 1 | Datapath powered down |
| oneResMode | output | 1 | Single-resistor reference |
| interpSel | output | 2 | Interpolation rate select |
| modSel | output | 2 | Modulation mode select |
| zeroStuff | output | 1 | Zero-stuffing enable |
| realMix | output | 1 | Real mix (1) or complex mix (0) |
| negSideband | output | 1 | Complex modulation sign |
| dclkOutSel | output | 1 | Data-clock output instead of lock output |
| straightBin | output | 1 | Straight binary input format |
| onePortMode | output | 1 | Interleaved single-port input |
| dclkStrong | output | 1 | Strong data-clock driver |
| dclkInvert | output | 1 | Invert data clock |
| opClkInvert | output | 1 | Invert single-port clock |
| iqSelInvert | output | 1 | Invert IQ select polarity |
| qiOrder | output | 1 | Q-first pair ordering |
| dpRestart | output | 1 | One-cycle datapath restart pulse |

## Verification
The soft-reset clear and a host write to 0x01 or 0x02 can land on the same clock edge. This happens when the host writes one of those bytes in the cycle right after setting the reset bit. A second collision is a write to address 0x00 during that same restart cycle.

The bench provokes both collisions in directed steps, and its random traffic also re-arms soft resets back to back. The results are judged by reading back each byte and comparing the field outputs. A bench model applies the rule that the clear beats the write, while address 0x00 keeps accepting writes.

// File: rtl/txcfg_pkg.sv
package txcfg_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 3;
  localparam int IFACE_IDX = 0;
  localparam int SOFT_BIT  = 5;
  localparam int LOCK_BIT  = 1;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                softClr;
  } regStrobe_t;

  function automatic logic [DATA_W-1:0] regDefault(input int idx);
    case (idx)
      1:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    case (idx)
      0:       return 8'hDC;
      1:       return 8'hFF;
      2:       return 8'hF7;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/txcfg_ctrl.sv
module txcfg_ctrl
  import txcfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstHw,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              softReq,
  output regStrobe_t        strb
);
  logic softPend;

  always_ff @(posedge clk or posedge rstHw) begin
    if (rstHw) softPend <= 1'b0;
    else       softPend <= wrEn && (regAddr == ADDR_W'(IFACE_IDX)) && softReq;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    if (i == IFACE_IDX) begin : g_iface
      assign strb.wrSel[i] = wrEn && (regAddr == ADDR_W'(i));
    end else begin : g_data
      assign strb.wrSel[i] = wrEn && (regAddr == ADDR_W'(i)) && !softPend;
    end
  end

  assign strb.softClr = softPend;
endmodule

// File: rtl/txcfg_regs.sv
module txcfg_regs
  import txcfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstHw,
  input  regStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockIn,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regVec
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF  = regDefault(i);
    localparam logic [DATA_W-1:0] MASK = regMask(i);
    logic [DATA_W-1:0] q;
    if (i == IFACE_IDX) begin : g_keep
      always_ff @(posedge clk or posedge rstHw) begin
        if (rstHw)            q <= DEF;
        else if (strb.wrSel[i]) q <= wrData & MASK;
      end
    end else begin : g_clr
      always_ff @(posedge clk or posedge rstHw) begin
        if (rstHw)              q <= DEF;
        else if (strb.softClr)  q <= DEF;
        else if (strb.wrSel[i]) q <= wrData & MASK;
      end
    end
    assign regVec[i] = q;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (regAddr == ADDR_W'(i)) rdData = regVec[i];
    end
    if (regAddr == ADDR_W'(IFACE_IDX)) rdData[LOCK_BIT] = lockIn;
  end
endmodule

// File: rtl/txcfg_regbank.sv
module txcfg_regbank
  import txcfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstHw,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  output logic [7:0]        rdData,
  input  logic              lockIn,
  output logic              sdioBidir,
  output logic              lsbFirst,
  output logic              sleepEn,
  output logic              powerDown,
  output logic              oneResMode,
  output logic [1:0]        interpSel,
  output logic [1:0]        modSel,
  output logic              zeroStuff,
  output logic              realMix,
  output logic              negSideband,
  output logic              dclkOutSel,
  output logic              straightBin,
  output logic              onePortMode,
  output logic              dclkStrong,
  output logic              dclkInvert,
  output logic              opClkInvert,
  output logic              iqSelInvert,
  output logic              qiOrder,
  output logic              dpRestart
);
  regStrobe_t strb;
  logic [NUM_REGS-1:0][DATA_W-1:0] regVec;

  txcfg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstHw   (rstHw),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .softReq (wrData[SOFT_BIT]),
    .strb    (strb)
  );

  txcfg_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk     (clk),
    .rstHw   (rstHw),
    .strb    (strb),
    .regAddr (regAddr),
    .wrData  (wrData),
    .lockIn  (lockIn),
    .rdData  (rdData),
    .regVec  (regVec)
  );

  assign sdioBidir   = regVec[0][7];
  assign lsbFirst    = regVec[0][6];
  assign sleepEn     = regVec[0][4];
  assign powerDown   = regVec[0][3];
  assign oneResMode  = regVec[0][2];
  assign interpSel   = regVec[1][7:6];
  assign modSel      = regVec[1][5:4];
  assign zeroStuff   = regVec[1][3];
  assign realMix     = regVec[1][2];
  assign negSideband = regVec[1][1];
  assign dclkOutSel  = regVec[1][0];
  assign straightBin = regVec[2][7];
  assign onePortMode = regVec[2][6];
  assign dclkStrong  = regVec[2][5];
  assign dclkInvert  = regVec[2][4];
  assign opClkInvert = regVec[2][2];
  assign iqSelInvert = regVec[2][1];
  assign qiOrder     = regVec[2][0];
  assign dpRestart   = strb.softClr;
endmodule

// File: rtl/txcfg_regbank_chk.sv
module txcfg_regbank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstHw,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        wrData,
  input logic              wrEn,
  input logic [7:0]        rdData,
  input logic              lockIn,
  input logic              sdioBidir,
  input logic              lsbFirst,
  input logic              sleepEn,
  input logic              powerDown,
  input logic              oneResMode,
  input logic [1:0]        interpSel,
  input logic [1:0]        modSel,
  input logic              zeroStuff,
  input logic              realMix,
  input logic              negSideband,
  input logic              dclkOutSel,
  input logic              straightBin,
  input logic              onePortMode,
  input logic              dclkStrong,
  input logic              dclkInvert,
  input logic              opClkInvert,
  input logic              iqSelInvert,
  input logic              qiOrder,
  input logic              dpRestart
);
  logic [4:0] ifaceBits;
  logic [7:0] rateBits;
  logic [6:0] fmtBits;
  logic       softWr;
  assign ifaceBits = {sdioBidir, lsbFirst, sleepEn, powerDown, oneResMode};
  assign rateBits  = {interpSel, modSel, zeroStuff, realMix, negSideband, dclkOutSel};
  assign fmtBits   = {straightBin, onePortMode, dclkStrong, dclkInvert,
                      opClkInvert, iqSelInvert, qiOrder};
  assign softWr    = wrEn && (regAddr == '0) && wrData[5];

  assert_hw_defaults_R1: assert property (@(posedge clk)
    $fell(rstHw) |-> (ifaceBits == 5'd0 && rateBits == 8'h04 && fmtBits == 7'd0));

  assert_lock_fold_R2: assert property (@(posedge clk) disable iff (rstHw)
    (regAddr == '0) |-> (rdData[1] == lockIn && !rdData[5] && !rdData[0]));

  assert_gap_bit_R4: assert property (@(posedge clk) disable iff (rstHw)
    (regAddr == ADDR_W'(2)) |-> !rdData[3]);

  assert_unmapped_R5: assert property (@(posedge clk) disable iff (rstHw)
    (regAddr > ADDR_W'(2)) |-> (rdData == 8'h00));

  assert_restart_follows_R6: assert property (@(posedge clk) disable iff (rstHw)
    softWr |=> dpRestart);

  assert_restart_cause_R6: assert property (@(posedge clk) disable iff (rstHw)
    dpRestart |-> $past(softWr));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (rstHw)
    dpRestart |=> (rateBits == 8'h04 && fmtBits == 7'd0));

  assert_iface_kept_R7: assert property (@(posedge clk) disable iff (rstHw)
    (dpRestart && !(wrEn && regAddr == '0)) |=> $stable(ifaceBits));
endmodule

bind txcfg_regbank txcfg_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstHw(rstHw), .regAddr(regAddr), .wrData(wrData), .wrEn(wrEn),
  .rdData(rdData), .lockIn(lockIn), .sdioBidir(sdioBidir), .lsbFirst(lsbFirst),
  .sleepEn(sleepEn), .powerDown(powerDown), .oneResMode(oneResMode),
  .interpSel(interpSel), .modSel(modSel), .zeroStuff(zeroStuff),
  .realMix(realMix), .negSideband(negSideband), .dclkOutSel(dclkOutSel),
  .straightBin(straightBin), .onePortMode(onePortMode), .dclkStrong(dclkStrong),
  .dclkInvert(dclkInvert), .opClkInvert(opClkInvert), .iqSelInvert(iqSelInvert),
  .qiOrder(qiOrder), .dpRestart(dpRestart)
);

// File: tb/txcfg_regbank_tb_top.sv
`timescale 1ns/1ps
module txcfg_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rstHw = 1'b1;
  logic [7:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       lockIn = 1'b0;
  logic [7:0] rdData;
  logic sdioBidir, lsbFirst, sleepEn, powerDown, oneResMode;
  logic [1:0] interpSel, modSel;
  logic zeroStuff, realMix, negSideband, dclkOutSel;
  logic straightBin, onePortMode, dclkStrong, dclkInvert, opClkInvert, iqSelInvert, qiOrder;
  logic dpRestart;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0] m0, m1, m2;
  bit mPend;

  always #4 clk = ~clk;

  txcfg_regbank dut_i (
    .clk(clk), .rstHw(rstHw), .regAddr(regAddr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .lockIn(lockIn), .sdioBidir(sdioBidir), .lsbFirst(lsbFirst),
    .sleepEn(sleepEn), .powerDown(powerDown), .oneResMode(oneResMode),
    .interpSel(interpSel), .modSel(modSel), .zeroStuff(zeroStuff),
    .realMix(realMix), .negSideband(negSideband), .dclkOutSel(dclkOutSel),
    .straightBin(straightBin), .onePortMode(onePortMode), .dclkStrong(dclkStrong),
    .dclkInvert(dclkInvert), .opClkInvert(opClkInvert), .iqSelInvert(iqSelInvert),
    .qiOrder(qiOrder), .dpRestart(dpRestart)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd(input logic [7:0] a, input bit lk);
    case (a)
      8'd0:    return (m0 & 8'hDC) | {6'd0, lk, 1'b0};
      8'd1:    return m1;
      8'd2:    return m2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rdTag(input logic [7:0] a);
    case (a)
      8'd0: return "R2";
      8'd1: return "R3";
      8'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic modelReset();
    m0 = 8'h00; m1 = 8'h04; m2 = 8'h00; mPend = 0;
  endtask

  task automatic modelEdge(input bit w, input logic [7:0] a, input logic [7:0] d);
    if (mPend) begin
      m1 = 8'h04; m2 = 8'h00;
    end else if (w) begin
      if (a == 8'd1) m1 = d;
      if (a == 8'd2) m2 = d & 8'hF7;
    end
    if (w && a == 8'd0) m0 = d & 8'hDC;
    mPend = w && (a == 8'd0) && d[5];
  endtask

  task automatic checkAll();
    chk(rdData, expRd(regAddr, lockIn), rdTag(regAddr));
    chk({7'd0, dpRestart}, {7'd0, mPend}, "R6");
    chk({3'd0, sdioBidir, lsbFirst, sleepEn, powerDown, oneResMode},
        {3'd0, m0[7], m0[6], m0[4], m0[3], m0[2]}, "R9");
    chk({interpSel, modSel, zeroStuff, realMix, negSideband, dclkOutSel}, m1, "R9");
    chk({1'b0, straightBin, onePortMode, dclkStrong, dclkInvert, opClkInvert, iqSelInvert, qiOrder},
        {1'b0, m2[7:4], m2[2:0]}, "R9");
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d, input bit lk);
    @(negedge clk);
    wrEn = w; regAddr = a; wrData = d; lockIn = lk;
    #1 checkAll();
    @(posedge clk);
    modelEdge(w, a, d);
  endtask

  task automatic probe(input logic [7:0] a, input bit lk, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wrEn = 0; regAddr = a; wrData = 8'h00; lockIn = lk;
    #1 chk(rdData, exp, tag);
    checkAll();
    @(posedge clk);
    modelEdge(0, a, 8'h00);
  endtask

  task automatic hwReset();
    @(negedge clk);
    wrEn = 0; rstHw = 1'b1;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstHw = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    modelReset();
    hwReset();
    // R1 defaults after hardware reset
    probe(8'd0, 0, 8'h00, "R1");
    probe(8'd0, 1, 8'h02, "R1");
    probe(8'd1, 0, 8'h04, "R1");
    probe(8'd2, 0, 8'h00, "R1");
    // R3 / R4 full-byte writes
    step(1, 8'd1, 8'hFB, 0);
    step(1, 8'd2, 8'hFF, 0);
    probe(8'd1, 0, 8'hFB, "R3");
    probe(8'd2, 0, 8'hF7, "R4");
    // R2 masking on address 0
    step(1, 8'd0, 8'hC3, 1);
    probe(8'd0, 1, 8'hC2, "R2");
    // R6/R7/R8: soft reset with a colliding write
    step(1, 8'd0, 8'h3C, 0);
    step(1, 8'd1, 8'h9A, 0);
    probe(8'd1, 0, 8'h04, "R8");
    probe(8'd0, 0, 8'h1C, "R7");
    probe(8'd2, 0, 8'h00, "R6");
    // R7: write to address 0 in the restart cycle is kept
    step(1, 8'd0, 8'h20, 0);
    step(1, 8'd0, 8'h84, 0);
    probe(8'd0, 0, 8'h84, "R7");
    // R5: unmapped addresses
    step(1, 8'd1, 8'h5A, 0);
    step(1, 8'd3, 8'hFF, 0);
    step(1, 8'h80, 8'hFF, 0);
    probe(8'd3, 0, 8'h00, "R5");
    probe(8'd1, 0, 8'h5A, "R5");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [7:0] a, d;
      r = $urandom_range(0, 9);
      a = (r < 8) ? 8'(r % 3) : 8'($urandom_range(3, 255));
      d = 8'($urandom);
      if (a == 8'd0 && $urandom_range(0, 3) != 0) d[5] = 1'b0;
      step($urandom_range(0, 1) == 1, a, d, $urandom_range(0, 1) == 1);
    end
    // R1: hardware reset also clears address 0
    step(1, 8'd0, 8'hDC, 0);
    hwReset();
    probe(8'd0, 0, 8'h00, "R1");
    probe(8'd1, 0, 8'h04, "R1");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule